// File: doc/BRIEF.md
# Floppy Sector Scan Comparator

This block is the compare engine behind the scan-data commands of a floppy disk controller. The host streams reference bytes into a 16-entry FIFO, and the read channel delivers sector bytes one strobe at a time. For every disk byte the engine pops one host byte and compares the two under the condition picked by the command opcode: exact equality, host-less-or-equal, or host-greater-or-equal. As it goes it maintains the scan-hit and scan-not-satisfied flags of status register 2.

A command arrives as nine bytes on a byte strobe. The opcode is the first byte and the sector size code is the sixth. A drive-ready level is sampled when the ninth byte arrives. If the drive is ready, the engine scans sector after sector. It stops at the end of the first sector that satisfies the condition, raising an internal terminal-count pulse, and then drains any leftover host bytes without comparing them. If the drive is not ready, it reports failure at once.

Top module: `scan_compare`

## Requirements
- R1: The low five bits of the first command byte select the variant: 0x11 equal, 0x19 low-or-equal, 0x1D high-or-equal; the upper three bits are ignored. A first byte whose low five bits match none of these is discarded and does not count toward the nine command bytes.
- R2: A command takes effect on its ninth byte. Byte index 5 (the sixth byte) carries the size code n in bits 2:0, and a sector is 128 << n bytes, with n clamped to the maximum code (7 by default).
- R3: On the first byte of every sector, scan-not-satisfied is cleared and scan-hit is set before that byte's own comparison is applied.
- R4: Any byte whose host value differs from the disk value clears scan-hit (`st2Hit`). In the equal variant it also sets scan-not-satisfied (`st2NotSat`).
- R5: In the low-or-equal variant, a mismatch where the host byte is smaller than the disk byte clears scan-hit but does not set scan-not-satisfied; a host byte larger than the disk byte sets it.
- R6: In the high-or-equal variant, a mismatch where the host byte is larger than the disk byte clears scan-hit but does not set scan-not-satisfied; a host byte smaller than the disk byte sets it.
- R7: When the last byte of a sector is processed and scan-not-satisfied is clear afterwards, `scanDone` goes high and stays high. In the cycle after that byte's strobe edge, `termCount` and `cmdEnd` are each high for exactly one cycle.
- R8: When the last byte of a sector leaves scan-not-satisfied set, the scan does not finish and the next strobed byte is the first byte of a new sector.
- R9: After the scan is done, each disk strobe pops one host byte if the FIFO holds any and discards it. No comparison is made, and the status flags keep their values.
- R10: If `driveReady` is low when the ninth command byte arrives, `st0NotReady` and `st0Abnormal` are set, both ST2 flags are cleared, `cmdEnd` pulses for one cycle, and later disk strobes are ignored.
- R11: A disk strobe that finds the host FIFO empty is treated as a mismatch that sets scan-not-satisfied in every variant.
- R12: After reset every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdStb | input | 1 | Command byte strobe |
| cmdByte | input | 8 | Command byte |
| driveReady | input | 1 | Selected drive ready level, sampled on the ninth command byte |
| hostValid | input | 1 | Pushes `hostByte` into the FIFO (dropped when the FIFO is full) |
| hostByte | input | 8 | Host reference byte |
| diskStb | input | 1 | One sector byte read from the disk |
| diskByte | input | 8 | Sector byte from the disk |
| st2Hit | output | 1 | Scan-hit flag |
| st2NotSat | output | 1 | Scan-not-satisfied flag |
| st0NotReady | output | 1 | Not-ready flag of the result |
| st0Abnormal | output | 1 | Abnormal-termination flag of the result |
| scanDone | output | 1 | A sector satisfied the condition |
| termCount | output | 1 | One-cycle internal terminal-count pulse |
| cmdEnd | output | 1 | One-cycle pulse when the command ends |

## Verification
The assertions check several properties on every cycle:
- scan-hit and scan-not-satisfied are never set together;
- terminal-count lasts a single cycle, coincides with `cmdEnd`, and only appears with a satisfied, finished scan;
- the flags stay frozen while a finished scan drains bytes;
- a not-ready result carries clean ST2 flags.

The directed scenarios cover what needs a chosen data pattern: the direction-dependent mismatch rules of each variant, the exact byte on which a sector ends for a given size code, the restart of the flags at a sector boundary, FIFO underflow as a mismatch, and proof that drained bytes were really removed from the FIFO.

// File: rtl/scan_pkg.sv
package scan_pkg;

  typedef enum logic [1:0] {
    VAR_EQ   = 2'd0,
    VAR_LOW  = 2'd1,
    VAR_HIGH = 2'd2
  } scanVar_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrAll;     // new command: clear every flag
    logic setNr;      // drive not ready at start
    logic cmpEn;      // compare one byte pair
    logic firstByte;  // byte is the first of its sector
  } dpStb_t;

  typedef struct packed {
    logic     ok;
    scanVar_e v;
  } opDec_t;

  function automatic opDec_t decodeOp(input logic [7:0] op);
    opDec_t d;
    d.ok = 1'b1;
    d.v  = VAR_EQ;
    case (op[4:0])
      5'h11:   d.v = VAR_EQ;
      5'h19:   d.v = VAR_LOW;
      5'h1D:   d.v = VAR_HIGH;
      default: d.ok = 1'b0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/scan_fifo.sv
module scan_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] wData,
  input  logic             pop,
  output logic [WIDTH-1:0] rData,
  output logic             empty
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0] wrPtr, rdPtr;
  logic full;

  assign empty = (wrPtr == rdPtr);
  assign full  = (wrPtr[AW] != rdPtr[AW]) && (wrPtr[AW-1:0] == rdPtr[AW-1:0]);
  assign rData = mem[rdPtr[AW-1:0]];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (push && !full) wrPtr <= wrPtr + 1'b1;
      if (pop && !empty) rdPtr <= rdPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) mem[wrPtr[AW-1:0]] <= wData;
  end
endmodule

// File: rtl/scan_dp.sv
module scan_dp
  import scan_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  dpStb_t   stb,
  input  scanVar_e variant,
  input  logic [7:0] hostByte,
  input  logic     fifoEmpty,
  input  logic [7:0] diskByte,
  output logic     hit,
  output logic     notSat,
  output logic     notReady,
  output logic     abnormal,
  output logic     nsNext
);
  logic hitBase, nsBase, diff, relax, hitNext;

  always_comb begin
    hitBase = stb.firstByte ? 1'b1 : hit;
    nsBase  = stb.firstByte ? 1'b0 : notSat;
    diff    = fifoEmpty || (hostByte != diskByte);
    relax   = !fifoEmpty &&
              (((variant == VAR_LOW)  && (hostByte < diskByte)) ||
               ((variant == VAR_HIGH) && (hostByte > diskByte)));
    hitNext = hitBase && !diff;
    nsNext  = nsBase || (diff && !relax);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hit      <= 1'b0;
      notSat   <= 1'b0;
      notReady <= 1'b0;
      abnormal <= 1'b0;
    end else if (stb.clrAll) begin
      hit      <= 1'b0;
      notSat   <= 1'b0;
      notReady <= stb.setNr;
      abnormal <= stb.setNr;
    end else if (stb.cmpEn) begin
      hit    <= hitNext;
      notSat <= nsNext;
    end
  end
endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_pkg::*;
#(
  parameter int BASE_BYTES = 128,
  parameter int MAX_CODE   = 7,
  parameter int CMD_LEN    = 9,
  parameter int SIZE_POS   = 5
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     cmdStb,
  input  logic [7:0] cmdByte,
  input  logic     driveReady,
  input  logic     diskStb,
  input  logic     nsNext,
  output dpStb_t   stb,
  output scanVar_e variant,
  output logic     pop,
  output logic     scanDone,
  output logic     termCount,
  output logic     cmdEnd
);
  localparam int MAX_BYTES = BASE_BYTES << MAX_CODE;
  localparam int CW        = $clog2(MAX_BYTES) + 1;
  localparam int NW        = $clog2(CMD_LEN + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} state_e;

  state_e        state;
  logic [NW-1:0] cmdCnt;
  logic [2:0]    codeR;
  logic [CW-1:0] byteIdx, lastIdx;
  logic          acceptCmd, startNow, lastByte;
  opDec_t        dec;

  always_comb begin
    int code;
    code    = (int'(codeR) > MAX_CODE) ? MAX_CODE : int'(codeR);
    lastIdx = CW'((BASE_BYTES << code) - 1);
  end

  assign dec       = decodeOp(cmdByte);
  assign acceptCmd = cmdStb && (state != ST_RUN);
  assign startNow  = acceptCmd && (cmdCnt == NW'(CMD_LEN - 1));

  always_comb begin
    stb.clrAll    = startNow;
    stb.setNr     = startNow && !driveReady;
    stb.cmpEn     = (state == ST_RUN) && diskStb;
    stb.firstByte = (byteIdx == '0);
  end

  assign lastByte = stb.cmpEn && (byteIdx == lastIdx);
  assign pop      = diskStb && ((state == ST_RUN) || (state == ST_DONE));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cmdCnt    <= '0;
      codeR     <= '0;
      variant   <= VAR_EQ;
      byteIdx   <= '0;
      scanDone  <= 1'b0;
      termCount <= 1'b0;
      cmdEnd    <= 1'b0;
    end else begin
      termCount <= 1'b0;
      cmdEnd    <= 1'b0;
      if (acceptCmd) begin
        if (cmdCnt == '0) begin
          if (dec.ok) begin
            variant <= dec.v;
            cmdCnt  <= NW'(1);
          end
        end else if (startNow) begin
          cmdCnt   <= '0;
          byteIdx  <= '0;
          scanDone <= 1'b0;
          state    <= driveReady ? ST_RUN : ST_IDLE;
          cmdEnd   <= !driveReady;
        end else begin
          if (cmdCnt == NW'(SIZE_POS)) codeR <= cmdByte[2:0];
          cmdCnt <= cmdCnt + 1'b1;
        end
      end
      if (stb.cmpEn) begin
        byteIdx <= lastByte ? '0 : byteIdx + 1'b1;
        if (lastByte && !nsNext) begin
          state     <= ST_DONE;
          scanDone  <= 1'b1;
          termCount <= 1'b1;
          cmdEnd    <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/scan_compare.sv
module scan_compare
  import scan_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int BASE_BYTES = 128,
  parameter int MAX_CODE   = 7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdStb,
  input  logic [7:0] cmdByte,
  input  logic       driveReady,
  input  logic       hostValid,
  input  logic [7:0] hostByte,
  input  logic       diskStb,
  input  logic [7:0] diskByte,
  output logic       st2Hit,
  output logic       st2NotSat,
  output logic       st0NotReady,
  output logic       st0Abnormal,
  output logic       scanDone,
  output logic       termCount,
  output logic       cmdEnd
);
  dpStb_t     stb;
  scanVar_e   variant;
  logic       pop, fifoEmpty, nsNext;
  logic [7:0] fifoByte;

  scan_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) uFifo (
    .clk(clk), .rstN(rstN), .push(hostValid), .wData(hostByte),
    .pop(pop), .rData(fifoByte), .empty(fifoEmpty)
  );

  scan_ctrl #(.BASE_BYTES(BASE_BYTES), .MAX_CODE(MAX_CODE)) uCtrl (
    .clk(clk), .rstN(rstN), .cmdStb(cmdStb), .cmdByte(cmdByte),
    .driveReady(driveReady), .diskStb(diskStb), .nsNext(nsNext),
    .stb(stb), .variant(variant), .pop(pop), .scanDone(scanDone),
    .termCount(termCount), .cmdEnd(cmdEnd)
  );

  scan_dp uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .variant(variant),
    .hostByte(fifoByte), .fifoEmpty(fifoEmpty), .diskByte(diskByte),
    .hit(st2Hit), .notSat(st2NotSat), .notReady(st0NotReady),
    .abnormal(st0Abnormal), .nsNext(nsNext)
  );
endmodule

// File: rtl/scan_compare_chk.sv
module scan_compare_chk (
  input logic clk,
  input logic rstN,
  input logic cmdStb,
  input logic st2Hit,
  input logic st2NotSat,
  input logic st0NotReady,
  input logic scanDone,
  input logic termCount,
  input logic cmdEnd
);
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(st2Hit && st2NotSat));  // R4
  AST_TC_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    termCount |=> !termCount);  // R7
  AST_TC_SATISFIED: assert property (@(posedge clk) disable iff (!rstN)
    termCount |-> (scanDone && !st2NotSat && cmdEnd));  // R7
  AST_DRAIN_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (scanDone && !cmdStb) |=> ($stable(st2Hit) && $stable(st2NotSat)));  // R9
  AST_NR_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    st0NotReady |-> (!st2Hit && !st2NotSat && !scanDone));  // R10
endmodule

bind scan_compare scan_compare_chk uChk (
  .clk(clk), .rstN(rstN), .cmdStb(cmdStb), .st2Hit(st2Hit),
  .st2NotSat(st2NotSat), .st0NotReady(st0NotReady), .scanDone(scanDone),
  .termCount(termCount), .cmdEnd(cmdEnd)
);

// File: tb/sim_scan_compare.sv
module sim_scan_compare;
  logic clk = 1'b0, rstN = 1'b0;
  logic cmdStb = 1'b0, driveReady = 1'b1, hostValid = 1'b0, diskStb = 1'b0;
  logic [7:0] cmdByte = '0, hostByte = '0, diskByte = '0;
  logic st2Hit, st2NotSat, st0NotReady, st0Abnormal, scanDone, termCount, cmdEnd;
  int total = 0, bad = 0;
  logic endBefore9;

  always #2 clk = ~clk;

  scan_compare u0 (.*);

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sendCmd(input logic [7:0] op, input logic [2:0] code, input logic rdy);
    logic [7:0] b [9];
    b = '{op, 8'h00, 8'h01, 8'h00, 8'h01, {5'd0, code}, 8'h09, 8'h1B, 8'hFF};
    driveReady = rdy;
    for (int i = 0; i < 9; i++) begin
      if (i == 8) endBefore9 = cmdEnd;
      cmdStb = 1'b1;
      cmdByte = b[i];
      @(negedge clk);
    end
    cmdStb = 1'b0;
  endtask

  task automatic doByte(input logic [7:0] h, input logic [7:0] d);
    hostValid = 1'b1; hostByte = h;
    @(negedge clk);
    hostValid = 1'b0; diskStb = 1'b1; diskByte = d;
    @(negedge clk);
    diskStb = 1'b0;
  endtask

  task automatic stbOnly(input logic [7:0] d);
    diskStb = 1'b1; diskByte = d;
    @(negedge clk);
    diskStb = 1'b0;
  endtask

  task automatic fillEq(input int n);
    for (int i = 0; i < n; i++) doByte(8'(i * 7 + 3), 8'(i * 7 + 3));
  endtask

  task automatic testReset();
    check("R12 hit", st2Hit, 0);
    check("R12 notSat", st2NotSat, 0);
    check("R12 nr", st0NotReady, 0);
    check("R12 done", scanDone, 0);
    check("R12 tc", termCount, 0);
    check("R12 end", cmdEnd, 0);
  endtask

  task automatic testEqualSize();
    sendCmd(8'h51, 3'd1, 1'b1);          // R1 upper bits ignored, 256 bytes
    doByte(8'h40, 8'h40);
    check("R3 first hit", st2Hit, 1);
    check("R3 first notSat", st2NotSat, 0);
    fillEq(127);
    check("R2 not done at 128", scanDone, 0);
    fillEq(127);
    check("R2 not done at 255", scanDone, 0);
    doByte(8'h77, 8'h77);
    check("R7 done", scanDone, 1);
    check("R7 tc", termCount, 1);
    check("R7 end", cmdEnd, 1);
    check("R7 hit", st2Hit, 1);
    @(negedge clk);
    check("R7 tc one cycle", termCount, 0);
    check("R7 done held", scanDone, 1);
  endtask

  task automatic testEqualMiss();
    sendCmd(8'h11, 3'd0, 1'b1);
    check("R7 done cleared at start", scanDone, 0);
    fillEq(3);
    doByte(8'h10, 8'h11);
    check("R4 hit cleared", st2Hit, 0);
    check("R4 notSat set", st2NotSat, 1);
    fillEq(124);
    check("R8 no done", scanDone, 0);
    check("R8 no tc", termCount, 0);
    doByte(8'h05, 8'h05);
    check("R3 restart hit", st2Hit, 1);
    check("R3 restart notSat", st2NotSat, 0);
    fillEq(127);
    check("R8 second sector done", scanDone, 1);
  endtask

  task automatic testLow();
    sendCmd(8'h19, 3'd0, 1'b1);
    doByte(8'h10, 8'h20);
    check("R5 smaller hit", st2Hit, 0);
    check("R5 smaller notSat", st2NotSat, 0);
    fillEq(127);
    check("R5 smaller done", scanDone, 1);
    sendCmd(8'h19, 3'd0, 1'b1);
    doByte(8'h30, 8'h20);
    check("R5 larger notSat", st2NotSat, 1);
    fillEq(127);
    check("R5 larger no done", scanDone, 0);
    fillEq(128);
    check("R5 next sector done", scanDone, 1);
  endtask

  task automatic testHigh();
    sendCmd(8'h1D, 3'd0, 1'b1);
    doByte(8'h30, 8'h20);
    check("R6 larger hit", st2Hit, 0);
    check("R6 larger notSat", st2NotSat, 0);
    fillEq(127);
    check("R6 larger done", scanDone, 1);
    sendCmd(8'h1D, 3'd0, 1'b1);
    doByte(8'h10, 8'h20);
    check("R6 smaller notSat", st2NotSat, 1);
    fillEq(127);
    fillEq(128);
    check("R6 next sector done", scanDone, 1);
  endtask

  task automatic testUnderflowDrain();
    sendCmd(8'h19, 3'd0, 1'b1);
    stbOnly(8'hFF);                       // empty FIFO, low variant
    check("R11 underflow notSat", st2NotSat, 1);
    check("R11 underflow hit", st2Hit, 0);
    fillEq(127);
    fillEq(128);
    check("R11 recovers", scanDone, 1);
    for (int i = 0; i < 3; i++) begin
      hostValid = 1'b1; hostByte = 8'hAA;
      @(negedge clk);
    end
    hostValid = 1'b0;
    for (int i = 0; i < 4; i++) stbOnly(8'h00);
    check("R9 hit kept", st2Hit, 1);
    check("R9 notSat kept", st2NotSat, 0);
    check("R9 done kept", scanDone, 1);
    sendCmd(8'h11, 3'd0, 1'b1);
    doByte(8'h05, 8'h05);
    check("R9 drained bytes gone", st2Hit, 1);
    fillEq(127);
    check("R9 command finishes", scanDone, 1);
  endtask

  task automatic testNotReady();
    cmdStb = 1'b1; cmdByte = 8'h06;       // invalid opcode
    @(negedge clk);
    cmdStb = 1'b0;
    sendCmd(8'h11, 3'd0, 1'b0);
    check("R1 invalid byte not counted", endBefore9, 0);
    check("R10 end", cmdEnd, 1);
    check("R10 nr", st0NotReady, 1);
    check("R10 abnormal", st0Abnormal, 1);
    check("R10 hit zero", st2Hit, 0);
    check("R10 notSat zero", st2NotSat, 0);
    @(negedge clk);
    check("R10 end one cycle", cmdEnd, 0);
    stbOnly(8'h00);
    check("R10 strobe ignored", st2NotSat, 0);
    check("R10 no done", scanDone, 0);
  endtask

  initial begin
    #(4 * 150000);
    check("watchdog", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testEqualSize();
    testEqualMiss();
    testLow();
    testHigh();
    testUnderflowDrain();
    testNotReady();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule